// File: doc/BRIEF.md
# Dual-Clock Serial Frame Receiver

This block takes a serial bit stream from an external device that supplies its own bit clock and a qualifying enable line. Bits are gathered into fixed 96-bit frames in that foreign clock domain. When a frame completes, its upper part is frozen in a holding register and a single toggle crosses into the faster system clock. The holding register itself does not pass through a synchroniser. Once the toggle has been synchronised, the system side waits a few more cycles so that the held bits have settled. It then accepts the frame.

A small parser waits for accepted frames. For each one it emits one or two 32-bit words onto a RAM write port, as chosen by a software-set format input, and drops the rest of the frame. Each write advances the word address, which wraps at a configurable depth. A frame counter counts the accepted frames.

The RAM write port has no back-pressure: a write is a single-cycle strobe with address and data, and the RAM must take it in that cycle. The serial side also has no stall. The serial clock is slower than the system clock, and the parser needs at most three system cycles per frame, so no frame can arrive while the parser is still busy.

Top module: `serial_frame_rx`

## Requirements
- R1: A serial bit is captured only on a rising serial-clock edge at which the enable input is high. Bits presented while enable is low do not appear in any frame.
- R2: A frame is exactly 96 captured bits. The first bit captured becomes frame bit 95 and the last becomes frame bit 0. The next frame starts with the following captured bit.
- R3: With the format input low (one-word format), each frame produces exactly one write, carrying frame bits [95:64].
- R4: With the format input high (two-word format), each frame produces two writes on consecutive system cycles. The first carries frame bits [95:64] and the second carries frame bits [63:32].
- R5: No other frame bits are ever written: bits [31:0] never appear, and in the one-word format bits [63:32] never appear either.
- R6: The write address starts at 0 and advances by one after every write. It wraps from RAM_DEPTH-1 back to 0, and it holds its value in cycles without a write.
- R7: The frame counter advances by one for each accepted frame and wraps at its width. The first write of that frame is presented in the same cycle in which the counter shows the new value.
- R8: While the system reset is asserted, the write strobe is low, the address is 0 and the frame counter is 0.
- R9: The format input is sampled when a frame is accepted. A change between frames applies from the next frame onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Bit clock supplied by the external device |
| ser_en | input | 1 | Qualifies ser_data on each ser_clk rising edge |
| ser_data | input | 1 | Serial data, first bit = frame MSB |
| sys_clk | input | 1 | System clock, faster than ser_clk |
| sys_rst_n | input | 1 | Active-low asynchronous reset, also released into the serial domain through a synchroniser |
| fmt_two | input | 1 | Software format: 0 = one word per frame, 1 = two words |
| ram_wr_en | output | 1 | Single-cycle write strobe |
| ram_wr_addr | output | AW | Word address of the current write |
| ram_wr_data | output | 32 | Word being written |
| frame_count | output | COUNT_W | Number of accepted frames, modulo 2^COUNT_W |

## Verification
The bench builds the block with RAM_DEPTH of 5 and COUNT_W of 3. With a depth that is not a power of two, the address wraps early and at a value that a plain power-of-two rollover would miss. A narrow counter lets nine frames carry it through its wrap. Synchroniser and settle depths stay at 2. Serial and system clocks run at unrelated periods, so trigger arrival drifts across system cycles from frame to frame. Frames are sent with and without enable gaps, with garbage data during the gaps, and back to back, so that the bit counter's restart between frames is covered.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int FRAME_BITS = 96;
  localparam int WORD_BITS  = 32;
  localparam int KEEP_BITS  = 2 * WORD_BITS;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HI   = 2'd1,
    PS_LO   = 2'd2
  } parse_st_e;
endpackage

// File: rtl/sfr_serial_capture.sv
module sfr_serial_capture
  import sfr_pkg::*;
#(
  parameter int FB = FRAME_BITS,
  parameter int KB = KEEP_BITS
) (
  input  logic          ser_clk,
  input  logic          arst_n,
  input  logic          ser_en,
  input  logic          ser_data,
  output logic [KB-1:0] frame_hold,
  output logic          frame_tgl
);
  localparam int CW = $clog2(FB);

  // reset release synchronised into the serial domain
  logic [1:0] rst_sync;
  always_ff @(posedge ser_clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  logic srst_n;
  assign srst_n = rst_sync[1];

  logic [FB-2:0] shreg;
  logic [CW-1:0] bit_cnt;

  always_ff @(posedge ser_clk or negedge srst_n) begin
    if (!srst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      frame_hold <= '0;
      frame_tgl  <= 1'b0;
    end else if (ser_en) begin
      shreg <= {shreg[FB-3:0], ser_data};
      if (bit_cnt == CW'(FB - 1)) begin
        // last bit of the frame: freeze the bits the parser can use
        frame_hold <= shreg[FB-2 -: KB];
        frame_tgl  <= ~frame_tgl;
        bit_cnt    <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfr_toggle_sync.sv
module sfr_toggle_sync #(
  parameter int SYNC   = 2,
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [SYNC-1:0] sy;
  logic            last;
  logic            edge_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      last <= 1'b0;
    end else begin
      sy   <= {sy[SYNC-2:0], tgl_in};
      last <= sy[SYNC-1];
    end
  end
  assign edge_w = sy[SYNC-1] ^ last;

  generate
    if (SETTLE == 0) begin : g_direct
      assign pulse = edge_w;
    end else begin : g_delay
      logic [SETTLE-1:0] dly;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly <= '0;
        else        dly <= (dly << 1) | SETTLE'(edge_w);
      end
      assign pulse = dly[SETTLE-1];
    end
  endgenerate
endmodule

// File: rtl/sfr_parser.sv
module sfr_parser
  import sfr_pkg::*;
#(
  parameter int RAM_DEPTH = 1024,
  parameter int AW        = 10,
  parameter int COUNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig,
  input  logic [KEEP_BITS-1:0] frame_in,
  input  logic                 fmt_two,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [WORD_BITS-1:0] wr_data,
  output logic [COUNT_W-1:0]   frame_count
);
  parse_st_e            st;
  logic [KEEP_BITS-1:0] frame_q;
  logic                 two_q;
  logic [AW-1:0]        addr_nxt;

  assign addr_nxt = (wr_addr == AW'(RAM_DEPTH - 1)) ? '0 : wr_addr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= PS_IDLE;
      frame_q     <= '0;
      two_q       <= 1'b0;
      wr_addr     <= '0;
      frame_count <= '0;
    end else begin
      unique case (st)
        PS_IDLE: if (trig) begin
          frame_q     <= frame_in;
          two_q       <= fmt_two;
          frame_count <= frame_count + 1'b1;
          st          <= PS_HI;
        end
        PS_HI: begin
          wr_addr <= addr_nxt;
          st      <= two_q ? PS_LO : PS_IDLE;
        end
        PS_LO: begin
          wr_addr <= addr_nxt;
          st      <= PS_IDLE;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign wr_en   = (st != PS_IDLE);
  assign wr_data = (st == PS_LO) ? frame_q[WORD_BITS-1:0]
                                 : frame_q[KEEP_BITS-1 -: WORD_BITS];
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter  int RAM_DEPTH     = 1024,
  parameter  int COUNT_W       = 16,
  parameter  int SYNC_STAGES   = 2,
  parameter  int SETTLE_CYCLES = 2,
  localparam int AW            = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
  input  logic                 ser_clk,
  input  logic                 ser_en,
  input  logic                 ser_data,
  input  logic                 sys_clk,
  input  logic                 sys_rst_n,
  input  logic                 fmt_two,
  output logic                 ram_wr_en,
  output logic [AW-1:0]        ram_wr_addr,
  output logic [WORD_BITS-1:0] ram_wr_data,
  output logic [COUNT_W-1:0]   frame_count
);
  logic [KEEP_BITS-1:0] hold_w;
  logic                 tgl_w;
  logic                 trig_w;

  sfr_serial_capture #(.FB(FRAME_BITS), .KB(KEEP_BITS)) u_cap (
    .ser_clk    (ser_clk),
    .arst_n     (sys_rst_n),
    .ser_en     (ser_en),
    .ser_data   (ser_data),
    .frame_hold (hold_w),
    .frame_tgl  (tgl_w)
  );

  sfr_toggle_sync #(.SYNC(SYNC_STAGES), .SETTLE(SETTLE_CYCLES)) u_sync (
    .clk    (sys_clk),
    .rst_n  (sys_rst_n),
    .tgl_in (tgl_w),
    .pulse  (trig_w)
  );

  sfr_parser #(.RAM_DEPTH(RAM_DEPTH), .AW(AW), .COUNT_W(COUNT_W)) u_parse (
    .clk         (sys_clk),
    .rst_n       (sys_rst_n),
    .trig        (trig_w),
    .frame_in    (hold_w),
    .fmt_two     (fmt_two),
    .wr_en       (ram_wr_en),
    .wr_addr     (ram_wr_addr),
    .wr_data     (ram_wr_data),
    .frame_count (frame_count)
  );
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int RAM_DEPTH = 1024,
  parameter int COUNT_W   = 16,
  parameter int AW        = 10
) (
  input logic               sys_clk,
  input logic               sys_rst_n,
  input logic               fmt_two,
  input logic               ram_wr_en,
  input logic [AW-1:0]      ram_wr_addr,
  input logic [COUNT_W-1:0] frame_count
);
  a_r6_addr_advance: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ram_wr_en |=> ram_wr_addr == (($past(ram_wr_addr) == AW'(RAM_DEPTH - 1)) ? '0
                                  : $past(ram_wr_addr) + 1'b1));

  a_r6_addr_idle: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !ram_wr_en |=> $stable(ram_wr_addr));

  a_r7_count_step: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !$stable(frame_count) |-> frame_count == $past(frame_count) + 1'b1);

  a_r7_first_write: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !$stable(frame_count) |-> ram_wr_en);

  a_r4_second_write: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (!$stable(frame_count) && $past(fmt_two)) |=> ram_wr_en);

  a_r3_single_write: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (!$stable(frame_count) && !$past(fmt_two)) |=> !ram_wr_en);
endmodule

bind serial_frame_rx serial_frame_rx_chk #(
  .RAM_DEPTH(RAM_DEPTH), .COUNT_W(COUNT_W), .AW(AW)
) u_chk (
  .sys_clk     (sys_clk),
  .sys_rst_n   (sys_rst_n),
  .fmt_two     (fmt_two),
  .ram_wr_en   (ram_wr_en),
  .ram_wr_addr (ram_wr_addr),
  .frame_count (frame_count)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
  localparam int SYS_PERIOD = 26;
  localparam int SER_PERIOD = 38;
  localparam int DEPTH      = 5;
  localparam int CW         = 3;
  localparam int AW         = $clog2(DEPTH);

  logic ser_clk = 1'b0, sys_clk = 1'b0;
  logic ser_en = 1'b0, ser_data = 1'b0, sys_rst_n = 1'b0, fmt_two = 1'b0;
  logic          ram_wr_en;
  logic [AW-1:0] ram_wr_addr;
  logic [31:0]   ram_wr_data;
  logic [CW-1:0] frame_count;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
  always #(SER_PERIOD/2) ser_clk = ~ser_clk;

  serial_frame_rx #(.RAM_DEPTH(DEPTH), .COUNT_W(CW),
                    .SYNC_STAGES(2), .SETTLE_CYCLES(2)) u0 (
    .ser_clk(ser_clk), .ser_en(ser_en), .ser_data(ser_data),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .fmt_two(fmt_two),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr),
    .ram_wr_data(ram_wr_data), .frame_count(frame_count)
  );

  int checks = 0, errors = 0, nframes = 0, exp_addr = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference model: every system cycle, compare the write port to the queue
  always @(negedge sys_clk) begin
    if (sys_rst_n && !done) begin
      if (ram_wr_en) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5", "write with no word expected", ram_wr_data, 0);
        end else begin
          automatic logic [31:0] w = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(ram_wr_data == w, t, "write data", ram_wr_data, w);
          chk(ram_wr_addr == AW'(exp_addr), "R6", "write address", ram_wr_addr, exp_addr);
          exp_addr = (exp_addr + 1) % DEPTH;
        end
      end
    end
  end

  task automatic ser_cycle(input logic en, input logic d);
    @(negedge ser_clk);
    ser_en = en;
    ser_data = d;
  endtask

  // sends one frame, MSB first (R2); gap>0 inserts an idle cycle with
  // inverted garbage data before every gap-th bit (R1)
  task automatic send_frame(input logic fmt, input logic [95:0] f, input int gap,
                            input string tag);
    fmt_two = fmt;
    for (int i = 0; i < 96; i++) begin
      if (gap > 0 && i % gap == gap - 1) ser_cycle(1'b0, ~f[95-i]);
      ser_cycle(1'b1, f[95-i]);
    end
    exp_q.push_back(f[95:64]);
    tag_q.push_back(tag);
    if (fmt) begin
      exp_q.push_back(f[63:32]);
      tag_q.push_back(tag);
    end
    nframes++;
  endtask

  task automatic settle_and_count;
    ser_cycle(1'b0, 1'b1);
    repeat (40) @(negedge sys_clk);
    chk(frame_count == CW'(nframes), "R7", "frame count", frame_count, CW'(nframes));
    chk(exp_q.size() == 0, "R3", "words still pending", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge sys_clk);
    // R8 reset state
    chk(ram_wr_en == 1'b0, "R8", "strobe in reset", ram_wr_en, 0);
    chk(ram_wr_addr == '0, "R8", "address in reset", ram_wr_addr, 0);
    chk(frame_count == '0, "R8", "count in reset", frame_count, 0);
    sys_rst_n = 1'b1;
    repeat (6) ser_cycle(1'b0, 1'b0);

    send_frame(1'b0, 96'h0123_4567_89AB_CDEF_FEDC_BA98, 0, "R3");
    settle_and_count();
    // R9: format flipped between frames; R1: gaps with garbage data
    send_frame(1'b1, 96'hDEAD_BEEF_CAFE_F00D_1234_5678, 7, "R4");
    settle_and_count();
    send_frame(1'b1, 96'hFFFF_FFFF_0000_0001_8000_0000, 3, "R1");
    settle_and_count();
    send_frame(1'b0, 96'h5555_AAAA_3333_CCCC_0F0F_F0F0, 5, "R9");
    settle_and_count();
    // back-to-back pairs, same format within each pair (R2 restart)
    for (int k = 0; k < 3; k++) begin
      automatic logic fm = logic'(k % 2);
      send_frame(fm, {32'h1000_0000 + 32'(k), 32'h2000_0000 ^ 32'(k << 4),
                      32'hFFFF_FFFF}, 0, "R2");
      send_frame(fm, {32'h3000_0000 + 32'(k), 32'h4000_0000 | 32'(k), 32'h0},
                 (k == 2) ? 11 : 0, "R2");
      settle_and_count();
    end
    // R6 wrap and R5 no extra words were covered along the way
    chk(exp_q.size() == 0, "R5", "leftover expected words", exp_q.size(), 0);
    chk(nframes == 10, "R7", "frames sent", nframes, 10);
    done = 1;
    summary();
  end

  initial begin
    #(SYS_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    summary();
  end
endmodule